// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks load misses for a nonblocking data cache, so that later cache accesses keep flowing after a miss. Each load that misses claims a free tracking entry. The entry keeps the full byte address, the destination register number, the access width and a signed flag. The block asks memory for a line only when no other pending entry already waits for that same line.

When memory returns a line, the refill is latched. The block then walks every entry that waits on that line address, one per cycle and lowest index first. For each one it presents the destination register, the width and the load value. The value is extracted from the line and then sign- or zero-extended. Each entry that completes is freed. New allocations and further refills are held off until the walk has finished.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is pending. alloc_ready and refill_ready are 1, and done_valid is 0.
- R2: An allocation takes the lowest-numbered free entry. With all four entries pending, alloc_ready is 0 and an alloc_valid request is ignored: it raises no memory request and records no entry.
- R3: An accepted allocation raises mem_req_valid in the same cycle, with mem_req_block = address bits above the line offset, when no pending entry shares that line. When a pending entry does share the line, mem_req_valid stays 0 and the entry is still recorded.
- R4: A refill is accepted when refill_valid and refill_ready are both 1. From the next cycle until its walk ends, refill_ready and alloc_ready are both 0.
- R5: From the cycle after an accepted refill, each pending entry on that line completes in its own cycle, lowest index first. Completion drives done_valid=1 with that entry's destination and width, and the entry is then freed.
- R6: Entries that wait on other lines are neither completed nor freed by a refill.
- R7: Width codes are 0 = byte, 1 = halfword and 2 = word. The word is chosen by address bits [3:2] of a 16-byte line, with line byte k at bits 8k+7:8k of refill_line. The byte is chosen by address bits [1:0] and the halfword by address bit 1, both little-endian within the word.
- R8: With the signed flag set, a byte or halfword result is sign-extended to 32 bits. Otherwise it is zero-extended.
- R9: A refill that matches no pending entry produces no completion, and refill_ready returns to 1 two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Load miss to record |
| alloc_addr | input | 32 | Byte address of the missing load |
| alloc_dest | input | 5 | Destination register number |
| alloc_size | input | 2 | Access width code |
| alloc_signed | input | 1 | Sign-extend the result |
| alloc_ready | output | 1 | An entry is free and no refill walk is running |
| mem_req_valid | output | 1 | New line request to memory |
| mem_req_block | output | 28 | Line address of the request |
| refill_valid | input | 1 | Returned line is present |
| refill_block | input | 28 | Line address of the returned data |
| refill_line | input | 128 | Returned line data |
| refill_ready | output | 1 | Refill can be accepted |
| done_valid | output | 1 | A pending load completes this cycle |
| done_dest | output | 5 | Destination register of the completing load |
| done_size | output | 2 | Width code of the completing load |
| done_data | output | 32 | Extracted and extended load value |

## Verification
On every cycle, the assertions check the changes in the pending-entry count: one more after an accepted allocation, and one fewer after each completion. They also check that nothing changes while the block is idle. Further properties cover refill acceptance closing refill_ready, the end of a walk with no match, and zero-extension of unsigned bytes. Only the bench scenarios can show which entry is reused after a free, and the lowest-first order of completions. The same goes for request suppression for a line that is already pending, a full file ignoring a miss, and the exact lane and extension chosen for each offset.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int unsigned LOAD_W = 32;
endpackage

// File: rtl/mshr_first_one.sv
module mshr_first_one #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_extract.sv
module mshr_extract
  import mshr_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned WORDS  = LINE_BYTES / 4,
  localparam int unsigned LINE_W = LINE_BYTES * 8
) (
  input  logic [LINE_W-1:0] line,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [LOAD_W-1:0] value
);
  logic [31:0] words [WORDS];
  logic [31:0] word_sel;
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = line[w*32 +: 32];
  end

  assign word_sel = words[offset[OFF_W-1:2]];

  always_comb begin
    case (offset[1:0])
      2'd0:    byte_sel = word_sel[7:0];
      2'd1:    byte_sel = word_sel[15:8];
      2'd2:    byte_sel = word_sel[23:16];
      default: byte_sel = word_sel[31:24];
    endcase
    half_sel = offset[1] ? word_sel[31:16] : word_sel[15:0];
    case (size)
      SZ_BYTE: value = {{24{sgn & byte_sel[7]}}, byte_sel};
      SZ_HALF: value = {{16{sgn & half_sel[15]}}, half_sel};
      default: value = word_sel;
    endcase
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned ENTRIES    = 4,
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned BLK_W  = ADDR_W - OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic [1:0]        alloc_size,
  input  logic              alloc_signed,
  output logic              alloc_ready,
  output logic              mem_req_valid,
  output logic [BLK_W-1:0]  mem_req_block,
  input  logic              refill_valid,
  input  logic [BLK_W-1:0]  refill_block,
  input  logic [LINE_W-1:0] refill_line,
  output logic              refill_ready,
  output logic              done_valid,
  output logic [REG_W-1:0]  done_dest,
  output logic [1:0]        done_size,
  output logic [LOAD_W-1:0] done_data
);
  // Control state
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic               busy_q, busy_d;
  // Entry payload (no reset)
  logic [BLK_W-1:0]   blk_q  [ENTRIES];
  logic [OFF_W-1:0]   off_q  [ENTRIES];
  logic [REG_W-1:0]   dest_q [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic               sgn_q  [ENTRIES];
  // Latched refill
  logic [BLK_W-1:0]   rblk_q;
  logic [LINE_W-1:0]  rline_q;

  logic [ENTRIES-1:0] same_alloc, same_refill, wr_en;
  logic               free_found, match_found;
  logic [IDX_W-1:0]   free_idx, match_idx;
  logic               alloc_fire, refill_fire, pend_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign same_alloc[i]  = valid_q[i] && (blk_q[i] == alloc_addr[ADDR_W-1:OFF_W]);
    assign same_refill[i] = valid_q[i] && (blk_q[i] == rblk_q);
    assign wr_en[i]       = alloc_fire && (free_idx == IDX_W'(i));
  end

  mshr_first_one #(.N(ENTRIES)) free_pick_i (
    .req(~valid_q), .found(free_found), .idx(free_idx)
  );
  mshr_first_one #(.N(ENTRIES)) match_pick_i (
    .req(same_refill), .found(match_found), .idx(match_idx)
  );

  assign pend_hit      = |same_alloc;
  assign alloc_ready   = free_found && !busy_q;
  assign alloc_fire    = alloc_valid && alloc_ready;
  assign mem_req_valid = alloc_fire && !pend_hit;
  assign mem_req_block = alloc_addr[ADDR_W-1:OFF_W];
  assign refill_ready  = !busy_q;
  assign refill_fire   = refill_valid && refill_ready;
  assign done_valid    = busy_q && match_found;
  assign done_dest     = dest_q[match_idx];
  assign done_size     = size_q[match_idx];

  mshr_extract #(.LINE_BYTES(LINE_BYTES)) extract_i (
    .line(rline_q), .offset(off_q[match_idx]), .size(size_q[match_idx]),
    .sgn(sgn_q[match_idx]), .value(done_data)
  );

  // Next state
  always_comb begin
    valid_d = valid_q;
    if (alloc_fire) valid_d[free_idx] = 1'b1;
    if (done_valid) valid_d[match_idx] = 1'b0;
    busy_d = busy_q;
    if (refill_fire)                  busy_d = 1'b1;
    else if (busy_q && !match_found)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      busy_q  <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (refill_fire) begin
      rblk_q  <= refill_block;
      rline_q <= refill_line;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en[i]) begin
        blk_q[i]  <= alloc_addr[ADDR_W-1:OFF_W];
        off_q[i]  <= alloc_addr[OFF_W-1:0];
        dest_q[i] <= alloc_dest;
        size_q[i] <= alloc_size;
        sgn_q[i]  <= alloc_signed;
      end
    end
  end

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> $countones(valid_q) == $countones($past(valid_q)) + 1);
  // R5
  done_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> $countones(valid_q) + 1 == $countones($past(valid_q)));
  // R4
  refill_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_fire |=> !refill_ready && !alloc_ready);
  // R9
  walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!refill_ready && !done_valid) |=> refill_ready);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !alloc_valid) |=> $stable(valid_q));
  // R8
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_size == SZ_BYTE && !sgn_q[match_idx]) |-> done_data[31:8] == 24'd0);
endmodule

// File: tb/mshr_file_tb_top.sv
module mshr_file_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         alloc_valid, alloc_signed, alloc_ready, mem_req_valid;
  logic [31:0]  alloc_addr;
  logic [4:0]   alloc_dest;
  logic [1:0]   alloc_size;
  logic [27:0]  mem_req_block, refill_block;
  logic         refill_valid, refill_ready, done_valid;
  logic [127:0] refill_line;
  logic [4:0]   done_dest;
  logic [1:0]   done_size;
  logic [31:0]  done_data;
  int tests = 0;
  int fails = 0;

  localparam logic [127:0] LINE = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
  // {offset[3:0], size[1:0], signed, expected[31:0]}
  localparam logic [38:0] VEC [10] = '{
    {4'h0, 2'd2, 1'b0, 32'h3C2D1E0F},
    {4'h8, 2'd0, 1'b1, 32'hFFFFFF87},
    {4'h8, 2'd0, 1'b0, 32'h00000087},
    {4'h5, 2'd0, 1'b1, 32'h0000005A},
    {4'hA, 2'd1, 1'b1, 32'hFFFFB4A5},
    {4'h6, 2'd1, 1'b0, 32'h00007869},
    {4'hE, 2'd1, 1'b1, 32'hFFFFF0E1},
    {4'hC, 2'd2, 1'b0, 32'hF0E1D2C3},
    {4'hF, 2'd0, 1'b1, 32'hFFFFFFF0},
    {4'h2, 2'd1, 1'b0, 32'h00003C2D}
  };

  always #5 clk = ~clk;

  mshr_file dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
    .alloc_dest(alloc_dest), .alloc_size(alloc_size), .alloc_signed(alloc_signed),
    .alloc_ready(alloc_ready), .mem_req_valid(mem_req_valid), .mem_req_block(mem_req_block),
    .refill_valid(refill_valid), .refill_block(refill_block), .refill_line(refill_line),
    .refill_ready(refill_ready), .done_valid(done_valid), .done_dest(done_dest),
    .done_size(done_size), .done_data(done_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic alloc(input logic [31:0] a, input logic [4:0] d, input logic [1:0] sz,
                       input logic sg, input logic exp_req);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_addr = a; alloc_dest = d; alloc_size = sz; alloc_signed = sg;
    #1;
    check("R2 alloc_ready", 32'(alloc_ready), 32'd1);
    check("R3 mem_req_valid", 32'(mem_req_valid), 32'(exp_req));
    if (exp_req) check("R3 mem_req_block", 32'(mem_req_block), 32'(a[31:4]));
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic refill(input logic [27:0] b);
    @(negedge clk);
    refill_valid = 1'b1; refill_block = b; refill_line = LINE;
    @(posedge clk); #1;
    refill_valid = 1'b0;
  endtask

  task automatic expect_done(input string tag, input logic [4:0] d, input logic [1:0] sz,
                             input logic [31:0] v);
    @(negedge clk);
    check({tag, " done_valid"}, 32'(done_valid), 32'd1);
    check({tag, " done_dest"}, 32'(done_dest), 32'(d));
    check({tag, " done_size"}, 32'(done_size), 32'(sz));
    check({tag, " done_data"}, done_data, v);
  endtask

  task automatic expect_end(input string tag);
    @(negedge clk);
    check({tag, " no further completion"}, 32'(done_valid), 32'd0);
    check({tag, " walk still closing"}, 32'(refill_ready), 32'd0);
    @(negedge clk);
    check({tag, " refill_ready back"}, 32'(refill_ready), 32'd1);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_addr = '0; alloc_dest = '0; alloc_size = '0;
    alloc_signed = 1'b0; refill_valid = 1'b0; refill_block = '0; refill_line = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 alloc_ready", 32'(alloc_ready), 32'd1);
    check("R1 refill_ready", 32'(refill_ready), 32'd1);
    check("R1 done_valid", 32'(done_valid), 32'd0);

    // R7 R8 table of extraction vectors, one line each
    for (int i = 0; i < 10; i++) begin
      logic [31:0] a;
      a = 32'h1000 + 32'(i) * 32'h10 + 32'(VEC[i][38:35]);
      alloc(a, 5'(i), VEC[i][34:33], VEC[i][32], 1'b1);
      refill(a[31:4]);
      expect_done("R7 R8 vector", 5'(i), VEC[i][34:33], VEC[i][31:0]);
      expect_end("R5 vector");
    end

    // R3: second miss to pending line sends no request; R2 fill to four
    alloc(32'h100, 5'd10, 2'd2, 1'b0, 1'b1);
    alloc(32'h104, 5'd11, 2'd2, 1'b0, 1'b0);
    alloc(32'h200, 5'd12, 2'd2, 1'b0, 1'b1);
    alloc(32'h300, 5'd13, 2'd2, 1'b0, 1'b1);
    @(negedge clk);
    check("R2 full alloc_ready", 32'(alloc_ready), 32'd0);
    alloc_valid = 1'b1; alloc_addr = 32'h400; alloc_dest = 5'd20;
    #1;
    check("R2 full ignores miss", 32'(mem_req_valid), 32'd0);
    @(posedge clk); #1 alloc_valid = 1'b0;

    // R6: only the entry on line 0x20 completes
    refill(28'h20);
    expect_done("R6", 5'd12, 2'd2, 32'h3C2D1E0F);
    expect_end("R6");

    // R2: freed entry 2 is reused; R3 line 0x10 still pending
    alloc(32'h108, 5'd7, 2'd2, 1'b0, 1'b0);
    refill(28'h10);
    expect_done("R5 first", 5'd10, 2'd2, 32'h3C2D1E0F);
    check("R4 refill_ready low", 32'(refill_ready), 32'd0);
    check("R4 alloc_ready low", 32'(alloc_ready), 32'd0);
    expect_done("R5 second", 5'd11, 2'd2, 32'h78695A4B);
    expect_done("R5 third", 5'd7, 2'd2, 32'hB4A59687);
    expect_end("R5");

    // R9: ignored miss to 0x400 left nothing behind
    refill(28'h40);
    @(negedge clk);
    check("R9 no completion", 32'(done_valid), 32'd0);
    check("R9 busy one cycle", 32'(refill_ready), 32'd0);
    @(negedge clk);
    check("R9 refill_ready back", 32'(refill_ready), 32'd1);

    // R6: entry on line 0x30 survived earlier refills
    refill(28'h30);
    expect_done("R6 survivor", 5'd13, 2'd2, 32'h3C2D1E0F);
    expect_end("R6 survivor");
    check("R1 empty again", 32'(alloc_ready), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule